// File: doc/BRIEF.md
# Oversampling SPI Slave Port

This block is a mode-0 SPI slave that lives entirely in the system clock domain. The serial clock, the active-low chip select and the master-out data line are not used as clocks. Each one passes through a synchronizer, and the edges of the serial clock and the chip select are found by comparing the synchronized value with its value one cycle earlier. Because of this, the serial clock must run well below the system clock. Each edge needs a few system cycles to show up inside the block.

User logic supplies words to send through a valid/ready transmit port. The block holds one word in a buffer and moves it into the shift register at the start of a frame or at a word boundary. A word received from the master appears on a parallel output together with a valid strobe that lasts one cycle. A frame may carry any number of back-to-back words. If the buffer is empty when a word is due, the slave sends zeros.

Top module: `spi_os_slave`

## Requirements
- R1: During and after synchronous active-high reset, tx_ready is 1, rx_valid is 0, rx_data is 0 and spi_miso is 0.
- R2: While chip select is low, spi_mosi is captured on each rising edge of spi_sclk, most significant bit first. After WORD_W rising edges, rx_data holds the word and rx_valid is high for exactly one cycle.
- R3: A word on spi_miso is sent most significant bit first. Its first bit appears after chip select falls, and each later bit appears after a falling edge of spi_sclk, so the master can sample every bit on the rising edge.
- R4: A transmit word is taken only in a cycle where tx_valid and tx_ready are both 1. If tx_valid is raised while tx_ready is 0, nothing is stored.
- R5: tx_ready goes to 0 in the cycle after a word is accepted. It stays at 0 until the buffered word moves into the shift register, which happens either at a chip-select fall or at the spi_sclk falling edge after a word's last rising edge. tx_ready never falls without an accept.
- R6: If the buffer is empty when a new word starts, the slave sends a word of all zeros.
- R7: While chip select is high, spi_sclk edges shift nothing and raise no rx_valid. The next frame starts with a correctly aligned bit 0.
- R8: Raising chip select in the middle of a word throws away the partial word. No rx_valid is raised, and the next frame starts again at bit 0 and sends zeros unless a new word is loaded.
- R9: Words inside one frame follow each other with no gap. A word loaded after the frame has started is sent as the next word.
- R10: A word moved into the shift register at the trailing falling edge of a frame is kept across the chip-select high time. It is sent first in the next frame if no other word is waiting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| spi_sclk | input | 1 | Serial clock from the master, oversampled |
| spi_csn | input | 1 | Chip select from the master, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| tx_data | input | WORD_W | Word to send |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Transmit buffer is empty and can take a word |
| rx_data | output | WORD_W | Last word received |
| rx_valid | output | 1 | One-cycle strobe marking a new rx_data |

## Verification
The exchange is tried with several frame patterns:
- A single word. This shows basic bit order and timing.
- Two words back to back with the second word loaded mid-frame. This separates a correct word-boundary reload from a reload only at chip select.
- A two-word frame with only one word loaded. This exposes the zero fill.
- A word that is loaded late and then carried into the next frame. This separates keeping a primed word from clearing it at chip-select rise.

Further patterns cover an aborted partial word, clock toggling while deselected, and a valid raised against a low ready. Each shows whether stale bit counts or stray loads leak into the following frame.

// File: rtl/spi_os_pkg.sv
package spi_os_pkg;

   function automatic bit is_pow2(input int unsigned v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

   typedef struct packed {
      logic rise;
      logic fall;
   } edge_t;

endpackage

// File: rtl/spi_os_sync.sv
module spi_os_sync #(
   parameter int unsigned N      = 3,
   parameter int unsigned STAGES = 2,
   parameter logic [N-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("spi_os_sync: STAGES must be at least 2");
      end
      for (genvar b = 0; b < N; b++) begin : g_bit
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk) begin
            if (rst) chain <= {STAGES{RST_VAL[b]}};
            else     chain <= {chain[STAGES-2:0], d[b]};
         end
         assign q[b] = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/spi_os_edge.sv
module spi_os_edge
   import spi_os_pkg::*;
#(
   parameter int unsigned N = 2,
   parameter logic [N-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] s,
   output edge_t        e [N]
);
   logic [N-1:0] prev;

   always_ff @(posedge clk) begin
      if (rst) prev <= RST_VAL;
      else     prev <= s;
   end

   generate
      for (genvar b = 0; b < N; b++) begin : g_det
         assign e[b].rise = s[b] & ~prev[b];
         assign e[b].fall = ~s[b] & prev[b];
      end
   endgenerate
endmodule

// File: rtl/spi_os_rx.sv
module spi_os_rx #(
   parameter int unsigned WORD_W = 8,
   localparam int unsigned CW    = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              active,
   input  logic              sck_rise,
   input  logic              mosi,
   output logic [CW-1:0]     bit_cnt,
   output logic [WORD_W-1:0] rx_data,
   output logic              rx_valid
);
   localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

   logic [WORD_W-1:0] sr;
   logic [WORD_W-1:0] sr_next;

   assign sr_next = {sr[WORD_W-2:0], mosi};

   always_ff @(posedge clk) begin
      if (rst) begin
         bit_cnt  <= '0;
         sr       <= '0;
         rx_data  <= '0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (!active) begin
            bit_cnt <= '0;
         end else if (sck_rise) begin
            sr      <= sr_next;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST) begin
               rx_data  <= sr_next;
               rx_valid <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/spi_os_tx.sv
module spi_os_tx #(
   parameter int unsigned WORD_W = 8,
   localparam int unsigned CW    = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              active,
   input  logic              cs_start,
   input  logic              cs_stop,
   input  logic              sck_fall,
   input  logic [CW-1:0]     bit_cnt,
   input  logic [WORD_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   output logic              miso
);
   logic [WORD_W-1:0] hold_word;
   logic              hold_full;
   logic [WORD_W-1:0] shreg;
   logic              primed;
   logic              take;
   logic              consume;
   logic              at_boundary;

   assign tx_ready    = ~hold_full;
   assign take        = tx_valid & ~hold_full;
   assign at_boundary = (bit_cnt == '0);
   assign consume     = hold_full & ((cs_start & ~primed) |
                                     (active & sck_fall & at_boundary & ~cs_start));
   assign miso        = shreg[WORD_W-1];

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_word <= '0;
         hold_full <= 1'b0;
      end else if (consume) begin
         hold_full <= 1'b0;
      end else if (take) begin
         hold_word <= tx_data;
         hold_full <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         shreg  <= '0;
         primed <= 1'b0;
      end else if (cs_start) begin
         if (!primed) begin
            shreg  <= hold_full ? hold_word : '0;
            primed <= hold_full;
         end
      end else if (cs_stop) begin
         if (!primed || !at_boundary) begin
            shreg  <= '0;
            primed <= 1'b0;
         end
      end else if (active && sck_fall) begin
         if (at_boundary) begin
            shreg  <= hold_full ? hold_word : '0;
            primed <= hold_full;
         end else begin
            shreg  <= {shreg[WORD_W-2:0], 1'b0};
            primed <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/spi_os_slave.sv
module spi_os_slave
   import spi_os_pkg::*;
#(
   parameter int unsigned WORD_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              spi_sclk,
   input  logic              spi_csn,
   input  logic              spi_mosi,
   output logic              spi_miso,
   input  logic [WORD_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   output logic [WORD_W-1:0] rx_data,
   output logic              rx_valid
);
   localparam int unsigned CW   = $clog2(WORD_W);
   localparam int unsigned I_SCK = 0;
   localparam int unsigned I_CS  = 1;
   localparam int unsigned I_DAT = 2;
   localparam logic [2:0]  PIN_IDLE = 3'b010;

   generate
      if (!is_pow2(WORD_W)) begin : g_chk_w
         $error("spi_os_slave: WORD_W must be a power of two, at least 2");
      end
   endgenerate

   logic [2:0]    pins_s;
   edge_t         edges [2];
   logic          active;
   logic [CW-1:0] bit_cnt;

   spi_os_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   ({spi_mosi, spi_csn, spi_sclk}),
      .q   (pins_s)
   );

   spi_os_edge #(.N(2), .RST_VAL(PIN_IDLE[1:0])) u_edge (
      .clk (clk),
      .rst (rst),
      .s   (pins_s[1:0]),
      .e   (edges)
   );

   assign active = ~pins_s[I_CS];

   spi_os_rx #(.WORD_W(WORD_W)) u_rx (
      .clk      (clk),
      .rst      (rst),
      .active   (active),
      .sck_rise (edges[I_SCK].rise),
      .mosi     (pins_s[I_DAT]),
      .bit_cnt  (bit_cnt),
      .rx_data  (rx_data),
      .rx_valid (rx_valid)
   );

   spi_os_tx #(.WORD_W(WORD_W)) u_tx (
      .clk      (clk),
      .rst      (rst),
      .active   (active),
      .cs_start (edges[I_CS].fall),
      .cs_stop  (edges[I_CS].rise),
      .sck_fall (edges[I_SCK].fall),
      .bit_cnt  (bit_cnt),
      .tx_data  (tx_data),
      .tx_valid (tx_valid),
      .tx_ready (tx_ready),
      .miso     (spi_miso)
   );
endmodule

// File: rtl/spi_os_slave_chk.sv
module spi_os_slave_chk #(
   parameter int unsigned WORD_W = 8
) (
   input logic clk,
   input logic rst,
   input logic spi_sclk,
   input logic spi_csn,
   input logic spi_miso,
   input logic tx_valid,
   input logic tx_ready,
   input logic rx_valid
);
   logic       sclk_q, csn_q;
   logic [2:0] quiet;
   logic [2:0] cs_high;

   always_ff @(posedge clk) begin
      if (rst) begin
         sclk_q  <= 1'b0;
         csn_q   <= 1'b1;
         quiet   <= '0;
         cs_high <= '0;
      end else begin
         sclk_q <= spi_sclk;
         csn_q  <= spi_csn;
         if (spi_sclk != sclk_q || spi_csn != csn_q) quiet <= '0;
         else if (quiet != 3'd7)                      quiet <= quiet + 1'b1;
         if (!spi_csn)              cs_high <= '0;
         else if (cs_high != 3'd7)  cs_high <= cs_high + 1'b1;
      end
   end

   p_strobe_single_r2: assert property (@(posedge clk) disable iff (rst)
      rx_valid |=> !rx_valid);

   p_miso_quiet_r3: assert property (@(posedge clk) disable iff (rst)
      (quiet >= 3'd4) |-> $stable(spi_miso));

   p_ready_drops_r5: assert property (@(posedge clk) disable iff (rst)
      (tx_valid && tx_ready) |=> !tx_ready);

   p_ready_holds_r5: assert property (@(posedge clk) disable iff (rst)
      (tx_ready && !tx_valid) |=> tx_ready);

   p_idle_no_rx_r7: assert property (@(posedge clk) disable iff (rst)
      (cs_high >= 3'd4) |-> !rx_valid);
endmodule

bind spi_os_slave spi_os_slave_chk #(.WORD_W(WORD_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .spi_sclk (spi_sclk),
   .spi_csn  (spi_csn),
   .spi_miso (spi_miso),
   .tx_valid (tx_valid),
   .tx_ready (tx_ready),
   .rx_valid (rx_valid)
);

// File: tb/spi_os_slave_test.sv
module spi_os_slave_test;
   localparam int W = 8;
   localparam int H = 6;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         spi_sclk = 1'b0;
   logic         spi_csn = 1'b1;
   logic         spi_mosi = 1'b0;
   logic         spi_miso;
   logic [W-1:0] tx_data = '0;
   logic         tx_valid = 1'b0;
   logic         tx_ready;
   logic [W-1:0] rx_data;
   logic         rx_valid;

   int n_chk = 0;
   int n_fail = 0;
   int rx_cnt = 0;
   logic [W-1:0] rx_log [16];

   always #5 clk = ~clk;

   spi_os_slave #(.WORD_W(W)) uut (
      .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_csn(spi_csn),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .tx_data(tx_data),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
      .rx_valid(rx_valid)
   );

   always @(negedge clk) begin
      if (rx_valid) begin
         rx_log[rx_cnt % 16] <= rx_data;
         rx_cnt <= rx_cnt + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic push(input logic [W-1:0] d);
      @(negedge clk);
      tx_valid = 1'b1;
      tx_data  = d;
      while (!tx_ready) @(negedge clk);
      @(negedge clk);
      tx_valid = 1'b0;
   endtask

   task automatic shift_bits(input logic [W-1:0] mo, input int nb,
                             output logic [W-1:0] mi);
      mi = '0;
      for (int i = W - 1; i >= W - nb; i--) begin
         spi_mosi = mo[i];
         repeat (H) @(negedge clk);
         mi[i] = spi_miso;
         spi_sclk = 1'b1;
         repeat (H) @(negedge clk);
         spi_sclk = 1'b0;
      end
   endtask

   // frame of n words; optional push right after chip select falls
   task automatic frame(input int n, input logic [4*W-1:0] mo,
                        input bit do_push, input logic [W-1:0] pd,
                        output logic [4*W-1:0] mi);
      logic [W-1:0] w;
      mi = '0;
      @(negedge clk);
      spi_csn = 1'b0;
      if (do_push) begin
         repeat (5) @(negedge clk);
         push(pd);
      end
      for (int k = 0; k < n; k++) begin
         shift_bits(mo[k*W +: W], W, w);
         mi[k*W +: W] = w;
      end
      repeat (H) @(negedge clk);
      spi_csn = 1'b1;
      repeat (10) @(negedge clk);
   endtask

   task automatic check_rx(input int base, input int n, input logic [4*W-1:0] exp,
                           input string req);
      chk(rx_cnt - base == n, req, rx_cnt - base, n);
      for (int k = 0; k < n; k++)
         chk(rx_log[(base + k) % 16] == exp[k*W +: W], req,
             rx_log[(base + k) % 16], exp[k*W +: W]);
   endtask

   task automatic t_reset;
      chk(tx_ready == 1'b1, "R1 ready", tx_ready, 1);
      chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
      chk(rx_data == '0, "R1 rx_data", rx_data, 0);
      chk(spi_miso == 1'b0, "R1 miso", spi_miso, 0);
   endtask

   task automatic t_single;
      logic [4*W-1:0] mi;
      int base = rx_cnt;
      push(8'hA5);
      chk(tx_ready == 1'b0, "R5 ready low after accept", tx_ready, 0);
      frame(1, {24'h0, 8'h3C}, 1'b0, '0, mi);
      chk(mi[W-1:0] == 8'hA5, "R3 miso word", mi[W-1:0], 8'hA5);
      check_rx(base, 1, {24'h0, 8'h3C}, "R2 rx word");
      chk(tx_ready == 1'b1, "R5 ready after cs load", tx_ready, 1);
   endtask

   task automatic t_back_to_back;
      logic [4*W-1:0] mi;
      int base = rx_cnt;
      push(8'h5A);
      frame(2, {16'h0, 8'h7E, 8'h81}, 1'b1, 8'hC3, mi);
      chk(mi[2*W-1:0] == 16'hC35A, "R9 two words out", mi[2*W-1:0], 16'hC35A);
      check_rx(base, 2, {16'h0, 8'h7E, 8'h81}, "R9 two words in");
   endtask

   task automatic t_underrun;
      logic [4*W-1:0] mi;
      int base = rx_cnt;
      push(8'h96);
      frame(2, {16'h0, 8'h22, 8'h11}, 1'b0, '0, mi);
      chk(mi[2*W-1:0] == 16'h0096, "R6 zero fill", mi[2*W-1:0], 16'h0096);
      check_rx(base, 2, {16'h0, 8'h22, 8'h11}, "R6 rx");
   endtask

   task automatic t_carry;
      logic [4*W-1:0] mi;
      push(8'h0F);
      frame(1, {24'h0, 8'h55}, 1'b1, 8'hF0, mi);
      chk(mi[W-1:0] == 8'h0F, "R10 first frame", mi[W-1:0], 8'h0F);
      chk(tx_ready == 1'b1, "R5 ready after boundary load", tx_ready, 1);
      frame(1, {24'h0, 8'h55}, 1'b0, '0, mi);
      chk(mi[W-1:0] == 8'hF0, "R10 carried word", mi[W-1:0], 8'hF0);
      frame(1, {24'h0, 8'h55}, 1'b0, '0, mi);
      chk(mi[W-1:0] == 8'h00, "R10 carried once", mi[W-1:0], 8'h00);
   endtask

   task automatic t_ignore_valid;
      logic [4*W-1:0] mi;
      push(8'h33);
      @(negedge clk);
      tx_valid = 1'b1;
      tx_data  = 8'hCC;
      repeat (4) @(negedge clk);
      tx_valid = 1'b0;
      chk(tx_ready == 1'b0, "R4 ready stays low", tx_ready, 0);
      frame(1, {24'h0, 8'h00}, 1'b0, '0, mi);
      chk(mi[W-1:0] == 8'h33, "R4 held word kept", mi[W-1:0], 8'h33);
      frame(1, {24'h0, 8'h00}, 1'b0, '0, mi);
      chk(mi[W-1:0] == 8'h00, "R4 rejected word not stored", mi[W-1:0], 8'h00);
   endtask

   task automatic t_abort;
      logic [4*W-1:0] mi;
      logic [W-1:0] part;
      int base;
      push(8'h77);
      base = rx_cnt;
      @(negedge clk);
      spi_csn = 1'b0;
      shift_bits(8'hE0, 3, part);
      chk(part[W-1:W-3] == 3'b011, "R8 partial bits out", part[W-1:W-3], 3'b011);
      repeat (H) @(negedge clk);
      spi_csn = 1'b1;
      repeat (10) @(negedge clk);
      chk(rx_cnt == base, "R8 no strobe on abort", rx_cnt - base, 0);
      frame(1, {24'h0, 8'h4D}, 1'b0, '0, mi);
      check_rx(base, 1, {24'h0, 8'h4D}, "R8 realigned");
      chk(mi[W-1:0] == 8'h00, "R8 leftover discarded", mi[W-1:0], 8'h00);
   endtask

   task automatic t_idle_clock;
      logic [4*W-1:0] mi;
      int base = rx_cnt;
      spi_mosi = 1'b1;
      for (int i = 0; i < 5; i++) begin
         repeat (H) @(negedge clk);
         spi_sclk = 1'b1;
         repeat (H) @(negedge clk);
         spi_sclk = 1'b0;
      end
      repeat (10) @(negedge clk);
      chk(rx_cnt == base, "R7 no strobe while deselected", rx_cnt - base, 0);
      frame(1, {24'h0, 8'h12}, 1'b0, '0, mi);
      check_rx(base, 1, {24'h0, 8'h12}, "R7 aligned after idle clocks");
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst = 1'b0;
      repeat (3) @(negedge clk);
      t_reset();
      t_single();
      t_back_to_back();
      t_underrun();
      t_carry();
      t_ignore_valid();
      t_abort();
      t_idle_clock();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
      $finish;
   end
endmodule